// File: doc/BRIEF.md
# Granule Tag Guard

This block keeps a small on-chip memory of 4-bit allocation tags, one per 16-byte aligned granule of a modelled address space, and checks every load or store request against it. A request carries a 64-bit pointer. Bits 59:56 of the pointer hold the key that the software attached when it allocated the memory. Bits 55:0 are the address. For a load or store, the block looks up the stored tag of the addressed granule and reports a failure when the two differ.

The same request port also accepts three tag-maintenance commands. A single tag-set writes the pointer's key into one granule. A double tag-set writes it into two consecutive granules. A tag-get reads a granule's tag and returns a caller-supplied destination word with its key field replaced by that tag. All three locate their granule as base plus a signed immediate times 16, and none of them is checked against a key. A global override input turns checking off. A request can be marked as precisely reported or not. Failures that are not reported precisely set a sticky bit, one per privilege level 0 to 3, and software clears that bit by writing 0 to it.

Every request gets its response one clock cycle later. The data memory, exception delivery and caches are outside this block.

Top module: `tag_guard`

## Requirements
- R1: After a synchronous active-low reset, every stored tag is 0, `fail_status` is 0 and `rsp_valid` is 0.
- R2: The `req_op` encoding is 0 idle, 1 load, 2 store, 3 tag-set, 4 double tag-set and 5 tag-get; 6 and 7 act as idle. One cycle after any request, `rsp_valid` is 1. For a load or store, `rsp_fail` is 1 exactly when `req_ptr[59:56]` differs from the stored tag of granule `req_ptr[4 +: IDX_W]`.
- R3: A tag-set writes `req_ptr[59:56]` into the granule `(req_ptr[55:0] + req_imm*16) >> 4`, with `req_imm` signed. Only the low IDX_W bits of the granule number select an entry, so the index wraps.
- R4: A double tag-set writes the same tag into the computed granule and into the next one, which wraps from the last entry to entry 0.
- R5: A tag-get returns `req_dst` with bits 59:56 replaced by the tag of the computed granule. All other bits are unchanged. For any other operation, `rsp_data` is 0.
- R6: While `override_chk` is 1, no request reports a failure and no status bit is set.
- R7: A failing load or store with `req_precise` = 0 sets `fail_status[req_el]`. A failure with `req_precise` = 1 leaves `fail_status` unchanged.
- R8: A status bit stays set until a write with `stat_wr_en` = 1, `stat_wr_el` selecting it and `stat_wr_val` = 0. If an imprecise failure for that same level comes in the same cycle, the bit stays 1.
- R9: Tag-set, double tag-set and tag-get never report a failure, even when the pointer's key differs from the stored tag.
- R10: Pointer bits 63:60, and address bits above the granule index, do not affect the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see R2) |
| req_ptr | input | 64 | Pointer: key in 59:56, address in 55:0 |
| req_imm | input | IMM_W | Signed granule offset for tag commands |
| req_dst | input | 64 | Destination word merged by tag-get |
| req_el | input | 2 | Privilege level of the request |
| req_precise | input | 1 | 1: failure reported precisely, not accumulated |
| override_chk | input | 1 | Global check disable |
| stat_wr_en | input | 1 | Status bit write strobe |
| stat_wr_el | input | 2 | Level whose status bit is written |
| stat_wr_val | input | 1 | Value written to the status bit |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_fail | output | 1 | Tag-check failure |
| rsp_data | output | 64 | Tag-get result |
| fail_status | output | NUM_EL | Sticky imprecise-failure bits, one per level |

## Verification
The bench builds the block with IDX_W = 4, so there are 16 granules, and keeps the default 9-bit immediate. With only 16 entries, random pointers land on granules that were tagged earlier, so both matches and mismatches occur often. Signed immediates routinely push the computed granule past either end of the table, which exercises index wrap-around. The double tag-set is also driven across the boundary from entry 15 to entry 0.

// File: rtl/tagguard_pkg.sv
// Shared operation codes and helpers for the granule tag guard.
package tagguard_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_TSET  = 3'd3,
        OP_TSET2 = 3'd4,
        OP_TGET  = 3'd5
    } tg_op_e;

    // True for operations that are checked against the stored tag.
    function automatic logic is_access(input tg_op_e op);
        return (op == OP_LOAD) || (op == OP_STORE);
    endfunction

    // True for tag-maintenance commands.
    function automatic logic is_tag_cmd(input tg_op_e op);
        return (op == OP_TSET) || (op == OP_TSET2) || (op == OP_TGET);
    endfunction

endpackage

// File: rtl/tg_index.sv
// Granule index generation.
// Computes the checked-access index straight from the pointer, and the
// command index as pointer granule plus a sign-extended immediate.
// Assumes only the low IDX_W bits of the granule number select an entry,
// so higher address bits alias.
module tg_index #(
    parameter int GRAN_SHIFT = 4,
    parameter int IDX_W      = 8,
    parameter int IMM_W      = 9
) (
    input  logic [63:0]      ptr,
    input  logic [IMM_W-1:0] imm,
    output logic [IDX_W-1:0] chk_idx,
    output logic [IDX_W-1:0] cmd_idx,
    output logic [IDX_W-1:0] cmd_idx_nx
);
    localparam int EXT_W = IMM_W + IDX_W;

    logic [EXT_W-1:0] imm_ext;
    logic             unused_ptr_bits;

    // Sign-extend the immediate so truncation keeps modular arithmetic.
    always_comb imm_ext = {{IDX_W{imm[IMM_W-1]}}, imm};

    // Form the three indices used by the guard.
    always_comb begin
        chk_idx    = ptr[GRAN_SHIFT +: IDX_W];
        cmd_idx    = ptr[GRAN_SHIFT +: IDX_W] + imm_ext[IDX_W-1:0];
        cmd_idx_nx = cmd_idx + IDX_W'(1);
    end

    assign unused_ptr_bits = ^{ptr[63:GRAN_SHIFT+IDX_W], ptr[GRAN_SHIFT-1:0],
                               imm_ext[EXT_W-1:IDX_W]};
endmodule

// File: rtl/tg_store.sv
// Allocation tag storage: one TAG_W-bit register per granule.
// Two write selects share one write tag (for double tag-set); one read port.
// Assumes the two write indices differ when both are enabled.
module tg_store #(
    parameter int TAG_W = 4,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr2_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] wr2_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH*TAG_W-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [TAG_W-1:0] q;
        logic             hit;

        // Decide whether this entry is written this cycle.
        always_comb hit = (wr_en && (wr_idx == IDX_W'(g))) ||
                          (wr2_en && (wr2_idx == IDX_W'(g)));

        // Hold the entry's tag; reset to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wr_tag;
        end

        assign flat[g*TAG_W +: TAG_W] = q;
    end

    // Read mux for the addressed granule.
    always_comb rd_tag = flat[rd_idx*TAG_W +: TAG_W];
endmodule

// File: rtl/tg_sticky.sv
// Per-level sticky failure bits.
// A set request wins over a software write to the same level.
module tg_sticky #(
    parameter int NUM_EL = 4,
    parameter int EL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [EL_W-1:0]   set_el,
    input  logic              wr_en,
    input  logic [EL_W-1:0]   wr_el,
    input  logic              wr_val,
    output logic [NUM_EL-1:0] status
);
    for (genvar e = 0; e < NUM_EL; e++) begin : g_lvl
        // Update one level's bit: failure first, then software write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status[e] <= 1'b0;
            else if (set_en && (set_el == EL_W'(e)))
                status[e] <= 1'b1;
            else if (wr_en && (wr_el == EL_W'(e)))
                status[e] <= wr_val;
        end
    end
endmodule

// File: rtl/tag_guard.sv
// Granule tag guard top.
// Decodes one request per cycle, checks loads and stores against the stored
// granule tag, runs tag-set / double tag-set / tag-get commands, and
// registers the response one cycle later. Assumes the key sits at
// bits TAG_LSB+TAG_W-1:TAG_LSB of the pointer.
module tag_guard
    import tagguard_pkg::*;
#(
    parameter int TAG_W      = 4,
    parameter int TAG_LSB    = 56,
    parameter int GRAN_SHIFT = 4,
    parameter int IDX_W      = 8,
    parameter int IMM_W      = 9,
    parameter int NUM_EL     = 4,
    parameter int EL_W       = $clog2(NUM_EL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [63:0]       req_ptr,
    input  logic [IMM_W-1:0]  req_imm,
    input  logic [63:0]       req_dst,
    input  logic [EL_W-1:0]   req_el,
    input  logic              req_precise,
    input  logic              override_chk,
    input  logic              stat_wr_en,
    input  logic [EL_W-1:0]   stat_wr_el,
    input  logic              stat_wr_val,
    output logic              rsp_valid,
    output logic              rsp_fail,
    output logic [63:0]       rsp_data,
    output logic [NUM_EL-1:0] fail_status
);
    tg_op_e           op;
    logic [IDX_W-1:0] chk_idx, cmd_idx, cmd_idx_nx, rd_idx;
    logic [TAG_W-1:0] ptr_tag, rd_tag;
    logic             access, wr_en, wr2_en, fail_now, imprecise_set;
    logic [63:0]      data_now;

    // Decode the request.
    always_comb begin
        op      = tg_op_e'(req_op);
        access  = req_valid && is_access(op);
        ptr_tag = req_ptr[TAG_LSB +: TAG_W];
        wr_en   = req_valid && ((op == OP_TSET) || (op == OP_TSET2));
        wr2_en  = req_valid && (op == OP_TSET2);
        rd_idx  = access ? chk_idx : cmd_idx;
    end

    tg_index #(
        .GRAN_SHIFT(GRAN_SHIFT),
        .IDX_W     (IDX_W),
        .IMM_W     (IMM_W)
    ) u_index (
        .ptr       (req_ptr),
        .imm       (req_imm),
        .chk_idx   (chk_idx),
        .cmd_idx   (cmd_idx),
        .cmd_idx_nx(cmd_idx_nx)
    );

    tg_store #(
        .TAG_W(TAG_W),
        .IDX_W(IDX_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr2_en (wr2_en),
        .wr_idx (cmd_idx),
        .wr2_idx(cmd_idx_nx),
        .wr_tag (ptr_tag),
        .rd_idx (rd_idx),
        .rd_tag (rd_tag)
    );

    // Compare key and stored tag; merge the tag for tag-get.
    always_comb begin
        fail_now      = access && !override_chk && (ptr_tag != rd_tag);
        imprecise_set = fail_now && !req_precise;
        data_now      = '0;
        if (req_valid && (op == OP_TGET)) begin
            data_now                       = req_dst;
            data_now[TAG_LSB +: TAG_W]     = rd_tag;
        end
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fail  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fail  <= fail_now;
            rsp_data  <= data_now;
        end
    end

    tg_sticky #(
        .NUM_EL(NUM_EL),
        .EL_W  (EL_W)
    ) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_en(imprecise_set),
        .set_el(req_el),
        .wr_en (stat_wr_en),
        .wr_el (stat_wr_el),
        .wr_val(stat_wr_val),
        .status(fail_status)
    );
endmodule

// File: rtl/tag_guard_chk.sv
// Property checker for tag_guard, attached by bind.
// Tracks last cycle's request in its own registers and relates it to the
// registered response and status.
module tag_guard_chk #(
    parameter int TAG_W   = 4,
    parameter int TAG_LSB = 56,
    parameter int NUM_EL  = 4,
    parameter int EL_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [63:0]       req_dst,
    input logic              override_chk,
    input logic              stat_wr_en,
    input logic [EL_W-1:0]   stat_wr_el,
    input logic              stat_wr_val,
    input logic              rsp_valid,
    input logic              rsp_fail,
    input logic [63:0]       rsp_data,
    input logic [NUM_EL-1:0] fail_status
);
    localparam logic [63:0] KEY_MASK = 64'(((1 << TAG_W) - 1)) << TAG_LSB;

    logic              q_req, q_ovr, q_cmd, q_tget;
    logic [63:0]       q_dst;
    logic [NUM_EL-1:0] q_stat, q_clr;

    // Capture last cycle's request attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_req  <= 1'b0;
            q_ovr  <= 1'b0;
            q_cmd  <= 1'b0;
            q_tget <= 1'b0;
            q_dst  <= '0;
            q_stat <= '0;
            q_clr  <= '0;
        end else begin
            q_req  <= req_valid;
            q_ovr  <= req_valid && override_chk;
            q_cmd  <= req_valid && (req_op >= 3'd3) && (req_op <= 3'd5);
            q_tget <= req_valid && (req_op == 3'd5);
            q_dst  <= req_dst;
            q_stat <= fail_status;
            q_clr  <= (stat_wr_en && !stat_wr_val) ?
                      (NUM_EL'(1) << stat_wr_el) : '0;
        end
    end

    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == q_req);

    p_fail_has_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fail |-> rsp_valid);

    p_override_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q_ovr |-> !rsp_fail);

    p_cmd_never_fails_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q_cmd |-> !rsp_fail);

    p_tget_keeps_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q_tget |-> (((rsp_data ^ q_dst) & ~KEY_MASK) == 64'd0));

    p_sticky_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_stat & ~q_clr & ~fail_status) == '0));
endmodule

bind tag_guard tag_guard_chk #(
    .TAG_W  (TAG_W),
    .TAG_LSB(TAG_LSB),
    .NUM_EL (NUM_EL),
    .EL_W   (EL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_dst     (req_dst),
    .override_chk(override_chk),
    .stat_wr_en  (stat_wr_en),
    .stat_wr_el  (stat_wr_el),
    .stat_wr_val (stat_wr_val),
    .rsp_valid   (rsp_valid),
    .rsp_fail    (rsp_fail),
    .rsp_data    (rsp_data),
    .fail_status (fail_status)
);

// File: tb/sim_tag_guard.sv
`timescale 1ns/1ps
// Self-checking bench for tag_guard with a 16-granule table.
module sim_tag_guard;
    localparam int IDX_W = 4;
    localparam int IMM_W = 9;
    localparam int DEPTH = 1 << IDX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [63:0] req_ptr = '0;
    logic [IMM_W-1:0] req_imm = '0;
    logic [63:0] req_dst = '0;
    logic [1:0]  req_el = '0;
    logic        req_precise = 1'b0;
    logic        override_chk = 1'b0;
    logic        stat_wr_en = 1'b0;
    logic [1:0]  stat_wr_el = '0;
    logic        stat_wr_val = 1'b0;
    logic        rsp_valid, rsp_fail;
    logic [63:0] rsp_data;
    logic [3:0]  fail_status;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] m_tag [DEPTH];
    logic [3:0] m_stat;

    always #2.5 clk = ~clk;

    tag_guard #(.IDX_W(IDX_W), .IMM_W(IMM_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_ptr(req_ptr), .req_imm(req_imm), .req_dst(req_dst),
        .req_el(req_el), .req_precise(req_precise),
        .override_chk(override_chk), .stat_wr_en(stat_wr_en),
        .stat_wr_el(stat_wr_el), .stat_wr_val(stat_wr_val),
        .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_data(rsp_data),
        .fail_status(fail_status)
    );

    task automatic check(input string rq, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic int gran_of(input logic [63:0] p, input int imm);
        return (int'(p[7:4]) + imm) & (DEPTH - 1);
    endfunction

    function automatic logic [63:0] mkptr(input logic [3:0] key, input int g);
        logic [63:0] p;
        p = {$urandom, $urandom};
        p[59:56] = key;
        p[7:4] = 4'(g);
        return p;
    endfunction

    // One request (plus optional status write), called at a falling edge.
    task automatic apply(input logic [2:0] op, input logic [63:0] ptr,
                         input int imm, input logic [1:0] el, input logic prec,
                         input logic [63:0] dst, input logic ovr,
                         input logic we, input logic [1:0] wel,
                         input logic wv, input string rq);
        logic        e_fail;
        logic [63:0] e_data;
        int          g;
        e_fail = 1'b0;
        e_data = '0;
        if (op == 3'd1 || op == 3'd2) begin
            g = gran_of(ptr, 0);
            e_fail = !ovr && (ptr[59:56] != m_tag[g]);
        end else if (op == 3'd5) begin
            e_data = dst;
            e_data[59:56] = m_tag[gran_of(ptr, imm)];
        end
        for (int e = 0; e < 4; e++) begin
            if (e_fail && !prec && el == 2'(e)) m_stat[e] = 1'b1;
            else if (we && wel == 2'(e))        m_stat[e] = wv;
        end
        if (op == 3'd3 || op == 3'd4) m_tag[gran_of(ptr, imm)] = ptr[59:56];
        if (op == 3'd4) m_tag[gran_of(ptr, imm + 1)] = ptr[59:56];
        req_valid = 1'b1; req_op = op; req_ptr = ptr; req_imm = IMM_W'(imm);
        req_el = el; req_precise = prec; req_dst = dst; override_chk = ovr;
        stat_wr_en = we; stat_wr_el = wel; stat_wr_val = wv;
        @(negedge clk);
        check({rq, " valid"}, 64'(rsp_valid), 64'd1);
        check({rq, " fail"}, 64'(rsp_fail), 64'(e_fail));
        check({rq, " data"}, rsp_data, e_data);
        check({rq, " status"}, 64'(fail_status), 64'(m_stat));
        req_valid = 1'b0; stat_wr_en = 1'b0; override_chk = 1'b0;
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < DEPTH; i++) m_tag[i] = '0;
        m_stat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 status", 64'(fail_status), 64'd0);
        apply(3'd1, mkptr(4'h0, 9), 0, 2'd0, 1'b1, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R1 zero tag");
        // R3 tag-set and R2 load check, precise failure leaves status (R7)
        apply(3'd3, mkptr(4'h5, 3), 0, 2'd0, 1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R3 set");
        apply(3'd1, mkptr(4'h5, 3), 0, 2'd0, 1'b1, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R2 match");
        apply(3'd2, mkptr(4'h6, 3), 0, 2'd1, 1'b1, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R7 precise");
        // R3 negative immediate
        apply(3'd3, mkptr(4'h9, 3), -2, 2'd0, 1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R3 neg imm");
        apply(3'd1, mkptr(4'h9, 1), 0, 2'd0, 1'b1, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R3 neg check");
        // R4 double set wrapping 15 -> 0
        apply(3'd4, mkptr(4'hA, 14), 1, 2'd0, 1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R4 wrap");
        apply(3'd1, mkptr(4'hA, 15), 0, 2'd0, 1'b1, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R4 g15");
        apply(3'd2, mkptr(4'hA, 0), 0, 2'd0, 1'b1, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R4 g0");
        // R5 tag-get merge
        apply(3'd5, mkptr(4'h2, 0), 15, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 2'd0, 1'b0, "R5 get");
        // R6 override
        apply(3'd1, mkptr(4'h7, 3), 0, 2'd3, 1'b0, '0, 1'b1, 1'b0, 2'd0, 1'b0, "R6 override");
        // R7 imprecise sets level 2, R8 clear, then collision
        apply(3'd2, mkptr(4'h1, 3), 0, 2'd2, 1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R7 imprecise");
        apply(3'd0, '0, 0, 2'd0, 1'b0, '0, 1'b0, 1'b1, 2'd2, 1'b0, "R8 clear");
        apply(3'd1, mkptr(4'h1, 3), 0, 2'd1, 1'b0, '0, 1'b0, 1'b1, 2'd1, 1'b0, "R8 collide");
        // R9 mismatched key on commands
        apply(3'd5, mkptr(4'hF, 3), 0, 2'd0, 1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R9 get");
        apply(3'd3, mkptr(4'hF, 4), 0, 2'd0, 1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R9 set");
        // R10 high pointer bits ignored
        begin
            logic [63:0] p;
            p = mkptr(4'h5, 3);
            p[63:60] = 4'hF; p[55:8] = 48'hABCD_1234_5678;
            apply(3'd1, p, 0, 2'd0, 1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R10 high bits");
        end
        // Random mix covering R2..R9
        for (int i = 0; i < 600; i++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            apply(op, mkptr(4'($urandom), $urandom_range(0, DEPTH - 1)),
                  $urandom_range(0, 40) - 20, 2'($urandom), 1'($urandom),
                  {$urandom, $urandom}, ($urandom_range(0, 7) == 0),
                  ($urandom_range(0, 5) == 0), 2'($urandom), 1'($urandom),
                  "R2 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule